// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block gathers a small bus of peripheral interrupt lines (by default three: a periodic timer on line 0, a serial port on line 1 and a flash controller on line 2) and merges them into one interrupt request for a processor. Every line is level sensitive. A per-line parameter bit marks a line as coming from another clock domain. Such a line is retimed by one flop before use. Each retimed level is then captured in a pending register on every cycle.

Software programs an enable mask and a master enable with a single configuration write. The request output is high whenever the master enable is set and at least one enabled line is pending. A one-cycle read strobe returns, on the next cycle, the index of the most urgent enabled pending line. The lowest index is the most urgent. When no enabled line is pending, the read returns all-ones. Reads leave pending state untouched, so a handler clears an interrupt by quieting the peripheral itself.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `rd_valid_o` is 0, `rd_id_o` is all-ones, and the enable mask and master enable are both cleared, so no input line can raise `irq_o`.
- R2: A line whose bit in `ASYNC_MASK` is 0 reaches `irq_o` one clock edge after it changes. A line whose bit is 1 reaches `irq_o` after exactly two edges. The default `ASYNC_MASK` is 3'b110, which makes line 0 synchronous and lines 1 and 2 asynchronous.
- R3: Lines are level sensitive. `irq_o` stays high for as long as an enabled line is held high, and it falls no later than two edges after every line has gone low.
- R4: Enable mask bit i gates line i. A line whose mask bit is 0 can neither raise `irq_o` nor be reported by a read.
- R5: While the master enable is 0, `irq_o` stays low. Reads still report the enabled pending lines.
- R6: When several enabled lines are pending, the lowest-numbered one is reported.
- R7: A read strobe `rd_en_i` sampled at an edge produces `rd_valid_o` = 1 for the following cycle only. `rd_id_o` then holds the reported index, or all-ones (3 for the default width) when no enabled line is pending.
- R8: A read has no effect on pending state. Repeated reads while a line stays high return the same index, and `irq_o` stays high.
- R9: `cfg_we_i` loads `cfg_mask_i` into the enable mask and `cfg_master_i` into the master enable on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_src_i | input | N_SRC | Level interrupt lines, index 0 most urgent |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mask_i | input | N_SRC | Enable mask value to load |
| cfg_master_i | input | 1 | Master enable value to load |
| rd_en_i | input | 1 | Active-source read strobe |
| rd_valid_o | output | 1 | Read data valid, one cycle after the strobe |
| rd_id_o | output | ID_W | Reported source index, or all-ones if none |
| irq_o | output | 1 | Merged interrupt request |

## Verification
The bench targets the latency difference between synchronous and retimed lines. A design with a missing or doubled retiming flop would raise the request one edge early or one edge late. It also targets the fall of the request after all lines go low, where a sticky pending bit would hold the request high indefinitely. The remaining cases are simultaneous pending lines, where an inverted priority encoder would report line 2 instead of line 0, and masked lines, where a missing gate would leak into the request or the reported index. Finally, the bench reads repeatedly while a line is held high. A design that treated a read as an acknowledge would drop the request or report all-ones.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_SRC = 3,
  parameter logic [N_SRC-1:0] ASYNC_MASK = 3'b110,
  parameter int ID_W = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_src_i,
  input  logic             cfg_we_i,
  input  logic [N_SRC-1:0] cfg_mask_i,
  input  logic             cfg_master_i,
  input  logic             rd_en_i,
  output logic             rd_valid_o,
  output logic [ID_W-1:0]  rd_id_o,
  output logic             irq_o
);

  localparam logic [ID_W-1:0] NONE_ID = '1;

  logic [N_SRC-1:0] sync_q;
  logic [N_SRC-1:0] line_s;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] en_q;
  logic             master_q;
  logic [N_SRC-1:0] live;
  logic [ID_W-1:0]  top_id;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (ASYNC_MASK[i]) begin : g_async
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= irq_src_i[i];
      assign line_s[i] = sync_q[i];
    end else begin : g_sync
      assign sync_q[i] = 1'b0;
      assign line_s[i] = irq_src_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q   <= '0;
      en_q     <= '0;
      master_q <= 1'b0;
    end else begin
      pend_q <= line_s;
      if (cfg_we_i) begin
        en_q     <= cfg_mask_i;
        master_q <= cfg_master_i;
      end
    end

  assign live  = pend_q & en_q;
  assign irq_o = master_q & (|live);

  always_comb begin
    top_id = NONE_ID;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (live[i]) top_id = ID_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_id_o    <= NONE_ID;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_id_o <= top_id;
    end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N_SRC = 3,
  parameter int ID_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] irq_src_i,
  input logic             rd_en_i,
  input logic             rd_valid_o,
  input logic [ID_W-1:0]  rd_id_o,
  input logic             irq_o,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] en_q,
  input logic             master_q
);

  p_valid_follows_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);

  p_none_reads_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && $past(rd_en_i) && ($past(pend_q & en_q) == '0)) |-> (rd_id_o == '1));

  p_master_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !master_q |-> !irq_o);

  p_quiet_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(irq_src_i) == '0) && ($past(irq_src_i, 2) == '0)) |-> !irq_o);

  p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && $past(rd_en_i) && $past(pend_q[0] & en_q[0])) |-> (rd_id_o == '0));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_SRC(N_SRC), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src_i), .rd_en_i(rd_en_i),
  .rd_valid_o(rd_valid_o), .rd_id_o(rd_id_o), .irq_o(irq_o),
  .pend_q(pend_q), .en_q(en_q), .master_q(master_q)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] src = '0;
  logic       cfg_we = 0;
  logic [2:0] cfg_mask = '0;
  logic       cfg_master = 0;
  logic       rd_en = 0;
  logic       rd_valid;
  logic [1:0] rd_id;
  logic       irq;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_src_i(src), .cfg_we_i(cfg_we),
    .cfg_mask_i(cfg_mask), .cfg_master_i(cfg_master), .rd_en_i(rd_en),
    .rd_valid_o(rd_valid), .rd_id_o(rd_id), .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic config_set(logic [2:0] m, logic me);
    cfg_mask = m; cfg_master = me; cfg_we = 1;
    edges(1);
    cfg_we = 0;
  endtask

  task automatic do_read(string req, int exp_id);
    rd_en = 1;
    edges(1);
    rd_en = 0;
    chk({req, " valid"}, rd_valid, 1);
    chk({req, " id"}, rd_id, exp_id);
    edges(1);
    chk({req, " valid pulse"}, rd_valid, 0);
  endtask

  task automatic t_reset;
    chk("R1 irq", irq, 0);
    chk("R1 valid", rd_valid, 0);
    chk("R1 id", rd_id, 3);
    src = 3'b111;
    edges(3);
    chk("R1 cleared enables", irq, 0);
    do_read("R1 cleared mask read", 3);
    src = '0;
    edges(2);
  endtask

  task automatic t_latency;
    config_set(3'b111, 1);
    chk("R9 config load", irq, 0);
    src = 3'b001;
    edges(1);
    chk("R2 sync line one edge", irq, 1);
    src = 3'b000;
    edges(2);
    chk("R3 fall after quiet", irq, 0);
    src = 3'b010;
    edges(1);
    chk("R2 async not after one edge", irq, 0);
    edges(1);
    chk("R2 async after two edges", irq, 1);
    src = 3'b000;
    edges(1);
    chk("R3 async still high one edge", irq, 1);
    edges(1);
    chk("R3 async fall two edges", irq, 0);
  endtask

  task automatic t_mask;
    config_set(3'b011, 1);
    src = 3'b100;
    edges(2);
    chk("R4 masked line no irq", irq, 0);
    do_read("R4 masked line read", 3);
    src = 3'b110;
    edges(2);
    chk("R4 enabled line irq", irq, 1);
    do_read("R4 masked higher index", 1);
    src = '0;
    edges(2);
  endtask

  task automatic t_master;
    config_set(3'b111, 0);
    src = 3'b001;
    edges(2);
    chk("R5 master off", irq, 0);
    do_read("R5 read with master off", 0);
    config_set(3'b111, 1);
    chk("R9 master on", irq, 1);
    src = '0;
    edges(2);
  endtask

  task automatic t_priority;
    src = 3'b110;
    edges(2);
    do_read("R6 lines 1,2", 1);
    src = 3'b111;
    edges(2);
    do_read("R6 all lines", 0);
    src = 3'b100;
    edges(2);
    do_read("R6 line 2 only", 2);
    src = '0;
    edges(2);
  endtask

  task automatic t_level_read;
    src = 3'b010;
    edges(2);
    do_read("R8 first read", 1);
    do_read("R8 second read", 1);
    chk("R8 irq held", irq, 1);
    edges(3);
    chk("R3 level held", irq, 1);
    src = '0;
    edges(2);
    chk("R3 cleared by line", irq, 0);
    do_read("R7 none pending", 3);
  endtask

  initial begin
    fork
      begin
        edges(3);
        rst_n = 1;
        edges(1);
        t_reset;
        t_latency;
        t_mask;
        t_master;
        t_priority;
        t_level_read;
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_run++;
          n_fail++;
          $display("FAIL watchdog actual=timeout expected=finish");
        end
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule